// File: doc/BRIEF.md
# DRAM Bank Open-Page Timing Tracker

This block sits in front of a DRAM command bus and keeps one open row per bank under an open-page policy. A read request names a bank and a row. The block compares it with its open-row table and sorts it into one of three classes: a page hit, an access to a precharged bank, or a row conflict. It then emits the precharge, activate and column-read commands that the class needs. Each gap between commands is timed by a programmable cycle count. A single-cycle data-valid pulse marks the cycle in which the read data would be on the bus, and a class code travels with that pulse.

Requests are served one at a time through a valid/ready handshake, and at most one command leaves the block per clock. Every activated row carries an age counter. When a row reaches the programmed maximum active time, the block closes it before it accepts any further request. A separate pulse input asks for a precharge of all banks at once. The four timing values are captured while reset is held, so the controller can change them only through a new reset.

Top module: `dram_page_tracker`

## Requirements
- R1: Each completed read reports `rd_status` with the `rd_valid` pulse. The code is 1 when the bank holds the requested row open, 2 when the bank holds no open row, and 3 when the bank holds a different row open.
- R2: For a conflict, a single-bank precharge (`cmd_op` 2) to the bank issues in the acceptance cycle. An activate (`cmd_op` 0) follows tRP cycles later, a column read (`cmd_op` 1) follows tRCD cycles after the activate, and `rd_valid` rises CL cycles after the read, for a total of tRP+tRCD+CL. No activate is ever sent to a bank that is already open.
- R3: For a request to a closed bank, the activate issues in the acceptance cycle and carries the requested bank and row. The column read follows tRCD cycles later, and `rd_valid` comes tRCD+CL cycles after acceptance.
- R4: For a page hit, the column read issues in the acceptance cycle with no precharge or activate, and `rd_valid` comes CL cycles after acceptance.
- R5: At most one command is issued per cycle on `cmd_valid`/`cmd_op`/`cmd_bank`/`cmd_row`. A column read only ever targets a bank that is open.
- R6: A row is force-closed by a single-bank precharge at the first idle cycle that is at least tRAS cycles after its activate. The precharge comes exactly tRAS cycles after the activate when the block is idle at that point.
- R7: A forced close takes priority over a waiting request. `req_ready` stays low while any row is overdue, so a request to that bank is accepted afterwards as code 2.
- R8: A one-cycle `pall_req` pulse, with no row overdue, produces an all-bank precharge (`cmd_op` 3) two cycles after the pulse cycle. The pulse closes every open row.
- R9: After a precharge issued outside a request (forced or all-bank), no request is accepted before tRP+1 cycles have passed. A waiting request is accepted exactly then.
- R10: The timing values are sampled only while `rst` is high. A value of zero is taken as one, and changing the pins outside reset has no effect.
- R11: After reset, `req_ready` is high and no command or data pulse is out. `req_ready` goes low in the cycle after acceptance and stays low until the data pulse, and `rd_valid` lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; timing values are sampled while high |
| cfg_trp | input | TW | Precharge-to-activate cycles |
| cfg_trcd | input | TW | Activate-to-read cycles |
| cfg_cl | input | TW | Read-to-data cycles |
| cfg_tras | input | TW | Maximum cycles a row stays open |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_bank | input | log2(NUM_BANKS) | Request bank |
| req_row | input | ROW_W | Request row |
| pall_req | input | 1 | Pulse asking for an all-bank precharge |
| cmd_valid | output | 1 | Command issued this cycle |
| cmd_op | output | 2 | 0 activate, 1 column read, 2 precharge one bank, 3 precharge all |
| cmd_bank | output | log2(NUM_BANKS) | Command bank |
| cmd_row | output | ROW_W | Row for an activate |
| rd_valid | output | 1 | One-cycle pulse: read data valid |
| rd_status | output | 2 | Class code of the completed read |

## Verification
Directed sequences take one bank through closed, hit and conflict in turn, so that each class's command spacing and latency is told apart from the others. They also land a request exactly on the cycle a row becomes overdue, which separates forced-close priority from plain hit handling. All-bank pulses and reconfiguration outside reset show whether the open-row table and the captured timing survive stimulus that should or should not touch them. A seeded random stream then hits a few banks and rows with random idle gaps and occasional all-bank pulses. This mixes hits, conflicts, forced closes and re-opens, and every issued precharge is checked for legality against a bank model.

// File: rtl/dpt_pkg.sv
`timescale 1ns/1ps
package dpt_pkg;
  typedef enum logic [1:0] {
    OP_ACT  = 2'd0,
    OP_RD   = 2'd1,
    OP_PRE  = 2'd2,
    OP_PREA = 2'd3
  } dpt_op_e;

  typedef enum logic [1:0] {
    CLS_NONE  = 2'd0,
    CLS_HIT   = 2'd1,
    CLS_EMPTY = 2'd2,
    CLS_CONF  = 2'd3
  } dpt_cls_e;

  typedef enum logic [2:0] {
    EN_IDLE,
    EN_TRP,
    EN_TRCD,
    EN_CL,
    EN_COOL
  } dpt_fsm_e;
endpackage

// File: rtl/dpt_lowest.sv
`timescale 1ns/1ps
module dpt_lowest #(
  parameter int N  = 32,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  vec,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
  assign any = |vec;

  // R7: the chosen bank is overdue and no lower-numbered bank is
  a_r7_pick_lowest: assert property (@(posedge clk) disable iff (rst)
    any |-> (vec[idx] && ((vec & ~({N{1'b1}} << idx)) == '0)));
endmodule

// File: rtl/dpt_bank_table.sv
`timescale 1ns/1ps
module dpt_bank_table #(
  parameter int NB = 32,
  parameter int RW = 16,
  parameter int TW = 8,
  localparam int BW = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [TW-1:0] tras,
  input  logic          act_en,
  input  logic [BW-1:0] act_bank,
  input  logic [RW-1:0] act_row,
  input  logic          close_en,
  input  logic [BW-1:0] close_bank,
  input  logic          close_all,
  input  logic [BW-1:0] look_bank,
  output logic          look_open,
  output logic [RW-1:0] look_row,
  output logic [NB-1:0] open_vec,
  output logic [NB-1:0] expired_vec
);
  logic [RW-1:0] row_mem [NB];
  logic [NB-1:0] open_q;

  always_ff @(posedge clk) begin
    if (act_en) row_mem[act_bank] <= act_row;
  end
  assign look_row  = row_mem[look_bank];
  assign look_open = open_q[look_bank];
  assign open_vec  = open_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= '0;
    end else if (close_all) begin
      open_q <= '0;
    end else begin
      if (close_en) open_q[close_bank] <= 1'b0;
      if (act_en)   open_q[act_bank]   <= 1'b1;
    end
  end

  for (genvar g = 0; g < NB; g++) begin : g_age
    logic [TW-1:0] age_q;
    always_ff @(posedge clk) begin
      if (rst)                                  age_q <= '0;
      else if (act_en && act_bank == BW'(g))    age_q <= TW'(1);
      else if (open_q[g] && age_q != {TW{1'b1}}) age_q <= age_q + TW'(1);
    end
    assign expired_vec[g] = open_q[g] && (age_q >= tras);
  end

  // R2: an activate never targets a bank that is still open
  a_r2_act_on_closed: assert property (@(posedge clk) disable iff (rst)
    act_en |-> !open_q[act_bank]);
  // R6: a single-bank precharge always closes a bank that was open
  a_r6_close_open_bank: assert property (@(posedge clk) disable iff (rst)
    (close_en && !close_all) |-> open_q[close_bank]);
  // R8: an all-bank precharge leaves nothing open
  a_r8_all_closed: assert property (@(posedge clk) disable iff (rst)
    close_all |=> (open_q == '0));
endmodule

// File: rtl/dram_page_tracker.sv
`timescale 1ns/1ps
module dram_page_tracker #(
  parameter int NUM_BANKS = 32,
  parameter int ROW_W     = 16,
  parameter int TW        = 8,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TW-1:0]     cfg_trp,
  input  logic [TW-1:0]     cfg_trcd,
  input  logic [TW-1:0]     cfg_cl,
  input  logic [TW-1:0]     cfg_tras,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic              pall_req,
  output logic              cmd_valid,
  output logic [1:0]        cmd_op,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ROW_W-1:0]  cmd_row,
  output logic              rd_valid,
  output logic [1:0]        rd_status
);
  import dpt_pkg::*;

  function automatic logic [TW-1:0] at_least_one(input logic [TW-1:0] v);
    return (v == '0) ? TW'(1) : v;
  endfunction

  logic [TW-1:0] trp_q, trcd_q, cl_q, tras_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      trp_q  <= at_least_one(cfg_trp);
      trcd_q <= at_least_one(cfg_trcd);
      cl_q   <= at_least_one(cfg_cl);
      tras_q <= at_least_one(cfg_tras);
    end
  end

  dpt_fsm_e          state, nx_state;
  logic [TW-1:0]     cnt, nx_cnt;
  logic [BANK_W-1:0] cur_bank, nx_bank;
  logic [ROW_W-1:0]  cur_row, nx_row;
  dpt_cls_e          cur_cls, nx_cls;
  logic              pall_pend;

  logic              issue, act_en, close_en, close_all, fin;
  dpt_op_e           op;
  logic [BANK_W-1:0] ibank;
  logic [ROW_W-1:0]  irow;

  logic                 look_open;
  logic [ROW_W-1:0]     look_row;
  logic [NUM_BANKS-1:0] open_vec, exp_vec;
  logic                 exp_any;
  logic [BANK_W-1:0]    exp_idx;

  dpt_bank_table #(.NB(NUM_BANKS), .RW(ROW_W), .TW(TW)) u_table (
    .clk(clk), .rst(rst), .tras(tras_q),
    .act_en(act_en), .act_bank(ibank), .act_row(irow),
    .close_en(close_en), .close_bank(ibank), .close_all(close_all),
    .look_bank(req_bank), .look_open(look_open), .look_row(look_row),
    .open_vec(open_vec), .expired_vec(exp_vec)
  );

  dpt_lowest #(.N(NUM_BANKS)) u_pick (
    .clk(clk), .rst(rst), .vec(exp_vec), .any(exp_any), .idx(exp_idx)
  );

  assign req_ready = (state == EN_IDLE) && !exp_any && !pall_pend;

  always_comb begin
    nx_state = state;
    nx_cnt   = cnt;
    nx_bank  = cur_bank;
    nx_row   = cur_row;
    nx_cls   = cur_cls;
    issue    = 1'b0;
    op       = OP_RD;
    ibank    = cur_bank;
    irow     = cur_row;
    act_en   = 1'b0;
    close_en = 1'b0;
    close_all = 1'b0;
    fin      = 1'b0;
    unique case (state)
      EN_IDLE: begin
        if (exp_any) begin
          issue = 1'b1; op = OP_PRE; ibank = exp_idx; irow = '0;
          close_en = 1'b1; nx_cnt = trp_q - TW'(1); nx_state = EN_COOL;
        end else if (pall_pend) begin
          issue = 1'b1; op = OP_PREA; ibank = '0; irow = '0;
          close_all = 1'b1; nx_cnt = trp_q - TW'(1); nx_state = EN_COOL;
        end else if (req_valid) begin
          nx_bank = req_bank; nx_row = req_row;
          ibank = req_bank;   irow = req_row;
          issue = 1'b1;
          if (look_open && look_row == req_row) begin
            op = OP_RD; nx_cls = CLS_HIT;
            nx_cnt = cl_q - TW'(1); nx_state = EN_CL;
          end else if (look_open) begin
            op = OP_PRE; close_en = 1'b1; nx_cls = CLS_CONF;
            nx_cnt = trp_q - TW'(1); nx_state = EN_TRP;
          end else begin
            op = OP_ACT; act_en = 1'b1; nx_cls = CLS_EMPTY;
            nx_cnt = trcd_q - TW'(1); nx_state = EN_TRCD;
          end
        end
      end
      EN_TRP: begin
        if (cnt == '0) begin
          issue = 1'b1; op = OP_ACT; act_en = 1'b1;
          nx_cnt = trcd_q - TW'(1); nx_state = EN_TRCD;
        end else nx_cnt = cnt - TW'(1);
      end
      EN_TRCD: begin
        if (cnt == '0) begin
          issue = 1'b1; op = OP_RD;
          nx_cnt = cl_q - TW'(1); nx_state = EN_CL;
        end else nx_cnt = cnt - TW'(1);
      end
      EN_CL: begin
        if (cnt == '0) begin
          fin = 1'b1; nx_state = EN_IDLE;
        end else nx_cnt = cnt - TW'(1);
      end
      EN_COOL: begin
        if (cnt == '0) nx_state = EN_IDLE;
        else           nx_cnt = cnt - TW'(1);
      end
      default: nx_state = EN_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= EN_IDLE;
      cnt       <= '0;
      cur_bank  <= '0;
      cur_row   <= '0;
      cur_cls   <= CLS_NONE;
      pall_pend <= 1'b0;
      cmd_valid <= 1'b0;
      cmd_op    <= 2'd0;
      cmd_bank  <= '0;
      cmd_row   <= '0;
      rd_valid  <= 1'b0;
      rd_status <= 2'd0;
    end else begin
      state     <= nx_state;
      cnt       <= nx_cnt;
      cur_bank  <= nx_bank;
      cur_row   <= nx_row;
      cur_cls   <= nx_cls;
      pall_pend <= (pall_pend && !close_all) || pall_req;
      cmd_valid <= issue;
      cmd_op    <= op;
      cmd_bank  <= ibank;
      cmd_row   <= irow;
      rd_valid  <= fin;
      rd_status <= fin ? cur_cls : CLS_NONE;
    end
  end

  // R5: a column read only targets an open bank
  a_r5_read_open_bank: assert property (@(posedge clk) disable iff (rst)
    (issue && op == OP_RD) |-> open_vec[ibank]);
  // R4: with CL of one, data follows the read on the next cycle
  a_r4_cl_one_data: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 2'd1 && cl_q == TW'(1)) |=> rd_valid);
  // R11: acceptance drops ready on the following cycle
  a_r11_ready_drops: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
  // R9: no request is taken in the cycle after an all-bank precharge
  a_r9_cool_blocks: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 2'd3) |-> !req_ready);
endmodule

// File: tb/dram_page_tracker_bench.sv
`timescale 1ns/1ps
module dram_page_tracker_bench;
  localparam int NB = 32, RW = 16, TW = 8, BW = 5;

  logic clk = 1'b0, rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [TW-1:0] cfg_trp = '0, cfg_trcd = '0, cfg_cl = '0, cfg_tras = '0;
  logic req_valid = 1'b0, req_ready, pall_req = 1'b0;
  logic [BW-1:0] req_bank = '0;
  logic [RW-1:0] req_row = '0;
  logic cmd_valid, rd_valid;
  logic [1:0] cmd_op, rd_status;
  logic [BW-1:0] cmd_bank;
  logic [RW-1:0] cmd_row;

  dram_page_tracker u_dram_page_tracker (
    .clk(clk), .rst(rst), .cfg_trp(cfg_trp), .cfg_trcd(cfg_trcd),
    .cfg_cl(cfg_cl), .cfg_tras(cfg_tras), .req_valid(req_valid),
    .req_ready(req_ready), .req_bank(req_bank), .req_row(req_row),
    .pall_req(pall_req), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_bank(cmd_bank), .cmd_row(cmd_row), .rd_valid(rd_valid),
    .rd_status(rd_status)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  int trp, trcd, cl, tras;
  bit m_open[NB];
  int m_row[NB], m_act[NB];
  bit busy = 0, done = 0;
  int cur_b, cur_r, ev_pre, ev_act, ev_cas, rd_cyc, rd_st, acc;
  int n_forced = 0, last_forced = -1, last_prea = -1;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Command monitor: keeps the bank model and checks command legality
  always @(negedge clk) begin
    if (!rst) begin
      if (cmd_valid) begin
        case (cmd_op)
          2'd0: begin
            chk(!m_open[cmd_bank], "R2 activate to closed bank", int'(m_open[cmd_bank]), 0);
            if (busy) begin
              ev_act = cyc;
              chk(int'(cmd_bank) == cur_b && int'(cmd_row) == cur_r,
                  "R3 activate address", int'(cmd_row), cur_r);
            end else chk(1'b0, "R11 activate without request", 1, 0);
            m_open[cmd_bank] = 1'b1;
            m_row[cmd_bank]  = int'(cmd_row);
            m_act[cmd_bank]  = cyc;
          end
          2'd1: begin
            chk(busy && int'(cmd_bank) == cur_b, "R5 read target", int'(cmd_bank), cur_b);
            chk(m_open[cmd_bank], "R5 read to open bank", int'(m_open[cmd_bank]), 1);
            ev_cas = cyc;
          end
          2'd2: begin
            if (busy) begin
              ev_pre = cyc;
              chk(int'(cmd_bank) == cur_b, "R2 precharge bank", int'(cmd_bank), cur_b);
            end else begin
              chk(m_open[cmd_bank] && (cyc - m_act[cmd_bank] >= tras),
                  "R6 forced precharge timing", cyc - m_act[cmd_bank], tras);
              n_forced++;
              last_forced = cyc;
            end
            m_open[cmd_bank] = 1'b0;
          end
          default: begin
            chk(!busy, "R8 all-bank precharge outside request", int'(busy), 0);
            for (int i = 0; i < NB; i++) m_open[i] = 1'b0;
            last_prea = cyc;
          end
        endcase
      end
      if (rd_valid) begin
        if (busy) begin
          rd_cyc = cyc;
          rd_st  = int'(rd_status);
        end else chk(1'b0, "R11 data pulse without request", 1, 0);
      end
    end
  end

  task automatic do_reset(int a, int b, int c, int d);
    @(negedge clk);
    rst = 1'b1;
    cfg_trp = TW'(a); cfg_trcd = TW'(b); cfg_cl = TW'(c); cfg_tras = TW'(d);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    trp = (a == 0) ? 1 : a; trcd = (b == 0) ? 1 : b;
    cl = (c == 0) ? 1 : c;  tras = (d == 0) ? 1 : d;
    for (int i = 0; i < NB; i++) m_open[i] = 1'b0;
    busy = 1'b0;
    #1;
    chk(req_ready, "R11 ready after reset", int'(req_ready), 1);
    chk(!cmd_valid && !rd_valid, "R11 quiet after reset", int'(cmd_valid), 0);
  endtask

  task automatic do_req(int b, int r);
    int exp_cls, exp_lat;
    string tag;
    @(negedge clk); #1;
    req_valid = 1'b1; req_bank = BW'(b); req_row = RW'(r);
    while (!req_ready) begin @(negedge clk); #1; end
    if (!m_open[b])          exp_cls = 2;
    else if (m_row[b] == r)  exp_cls = 1;
    else                     exp_cls = 3;
    exp_lat = (exp_cls == 1) ? cl : (exp_cls == 2) ? trcd + cl : trp + trcd + cl;
    cur_b = b; cur_r = r;
    ev_pre = -1; ev_act = -1; ev_cas = -1; rd_cyc = -1;
    busy = 1'b1;
    acc = cyc + 1;
    @(negedge clk); #1;
    req_valid = 1'b0;
    chk(!req_ready, "R11 ready drops after accept", int'(req_ready), 0);
    while (rd_cyc < 0) begin @(negedge clk); #1; end
    busy = 1'b0;
    chk(rd_st == exp_cls, "R1 class code", rd_st, exp_cls);
    tag = (exp_cls == 1) ? "R4 hit latency" : (exp_cls == 2) ? "R3 closed-bank latency"
                                                              : "R2 conflict latency";
    chk(rd_cyc - acc == exp_lat, tag, rd_cyc - acc, exp_lat);
    if (exp_cls == 1)
      chk(ev_pre < 0 && ev_act < 0 && ev_cas == acc, "R4 hit command timing", ev_cas, acc);
    else if (exp_cls == 2)
      chk(ev_pre < 0 && ev_act == acc && ev_cas == acc + trcd,
          "R3 closed-bank command timing", ev_cas, acc + trcd);
    else
      chk(ev_pre == acc && ev_act == acc + trp && ev_cas == ev_act + trcd,
          "R2 conflict command timing", ev_act, acc + trp);
    @(negedge clk); #1;
    chk(!rd_valid, "R11 data pulse lasts one cycle", int'(rd_valid), 0);
  endtask

  task automatic pulse_pall(output int p);
    @(negedge clk); #1;
    pall_req = 1'b1;
    p = cyc;
    @(negedge clk); #1;
    pall_req = 1'b0;
  endtask

  initial begin
    repeat (250000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int p, a5, a6, nf0;
    void'($urandom(32'd4711));
    do_reset(3, 4, 5, 30);

    // Class walk on one bank: closed, hit, conflict
    do_req(2, 10);
    do_req(2, 10);
    do_req(2, 11);
    do_req(3, 4);

    // All-bank precharge and the cool-down window
    pulse_pall(p);
    while (last_prea < p) begin @(negedge clk); #1; end
    chk(last_prea == p + 2, "R8 all-bank precharge timing", last_prea, p + 2);
    do_req(2, 11);
    chk(acc == last_prea + trp + 1, "R9 accept after cool-down", acc, last_prea + trp + 1);
    do_req(3, 4);
    pulse_pall(p);
    while (last_prea < p) begin @(negedge clk); #1; end

    // Forced close at exactly tRAS
    do_req(5, 7);
    a5 = ev_act;
    nf0 = n_forced;
    while (n_forced == nf0) begin @(negedge clk); #1; end
    chk(last_forced == a5 + tras, "R6 forced close cycle", last_forced, a5 + tras);

    // Request arrives as the row becomes overdue: forced close wins
    do_req(6, 1);
    a6 = ev_act;
    while (cyc < a6 + tras - 2) begin @(negedge clk); #1; end
    do_req(6, 1);
    chk(last_forced == a6 + tras, "R6 forced close before request", last_forced, a6 + tras);
    chk(acc == a6 + tras + trp + 1, "R7 request waits for forced close", acc, a6 + tras + trp + 1);

    // Pins changed outside reset have no effect
    cfg_trp = 8'd9; cfg_trcd = 8'd9; cfg_cl = 8'd9; cfg_tras = 8'd9;
    do_req(6, 1);
    chk(rd_cyc - acc == 5, "R10 timing held outside reset", rd_cyc - acc, 5);
    do_req(6, 2);
    chk(rd_cyc - acc == 3 + 4 + 5, "R10 conflict timing held", rd_cyc - acc, 12);

    // New values through reset, with a zero tRCD taken as one
    do_reset(2, 0, 3, 40);
    do_req(1, 1);
    chk(rd_cyc - acc == 1 + 3, "R10 reload and zero clamp", rd_cyc - acc, 4);

    // Seeded random traffic over a few banks and rows
    for (int k = 0; k < 150; k++) begin
      int gap;
      if ($urandom % 10 == 0) pulse_pall(p);
      gap = $urandom % 30;
      repeat (gap) @(negedge clk);
      do_req(int'($urandom % 4), int'($urandom % 3));
    end
    chk(n_forced > 0, "R6 forced closes occurred", n_forced, 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule